// File: doc/BRIEF.md
# Floating-Point Rounding and Exception-Flag Control Register

This block holds the floating-point control state of a scalar core. That state has two parts: a stored (dynamic) rounding mode and a set of sticky exception flags. Each floating-point operation presents its 3-bit rounding field. The block returns the rounding mode the arithmetic unit must use. If the resolved mode is a reserved encoding, the block instead raises an illegal-instruction indication.

The arithmetic unit reports a 5-bit exception vector with each result, and the block accumulates that vector into the sticky flags. The block also reports whenever the floating-point context has been changed. It does this with a one-cycle dirty pulse to the status logic.

Software reaches the state through a small CSR-style port. The port selects one of three views: the flags alone, the rounding mode alone, or the combined register that packs both. Reads are combinational on the current state. A write takes effect at the next clock edge.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset the flags are 0 and the stored rounding mode is 0, so a read of the combined view returns 0.
- R2: When `op_valid` is high and `op_rm` is 0 to 4, `eff_rm` equals `op_rm` and `rm_illegal` is low. The encodings are 0 nearest-even, 1 toward zero, 2 down, 3 up, 4 nearest with ties away from zero.
- R3: An `op_rm` of 7 makes `eff_rm` equal to the stored rounding mode.
- R4: `rm_illegal` is high during a valid operation whenever the resolved mode is above 4. This covers `op_rm` of 5 or 6, and `op_rm` of 7 when the stored mode is 5, 6 or 7.
- R5: On `exc_valid`, `exc_bits` is ORed into the sticky flags one cycle later, and no accumulate ever clears a flag. The bit order is inexact in bit 0, underflow in 1, overflow in 2, divide-by-zero in 3 and invalid in 4.
- R6: An accumulate with an all-zero exception vector leaves the flags unchanged and produces no dirty pulse.
- R7: `fp_dirty` is high for the cycle after a nonzero accumulate or after `fpr_wr`.
- R8: `csr_sel` value 1 selects the flags view, which reads and writes bits 4:0. Value 2 selects the rounding-mode view, which reads and writes bits 2:0.
- R9: `csr_sel` value 3 selects the combined view, with the flags in bits 4:0 and the rounding mode in bits 7:5. A write to it updates both fields at the same edge.
- R10: A CSR write to the flags view or the combined view overrides an accumulate in the same cycle. A write to the rounding-mode view alone lets the accumulate proceed.
- R11: Read bits above the selected view's fields are zero, and written bits above them are ignored. `csr_sel` value 0 reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A floating-point operation is presenting its rounding field |
| op_rm | input | 3 | Rounding field of the operation |
| eff_rm | output | 3 | Resolved rounding mode |
| rm_illegal | output | 1 | Resolved mode is reserved; the operation is illegal |
| exc_valid | input | 1 | Exception vector from the arithmetic unit is valid |
| exc_bits | input | 5 | Exception vector to accumulate |
| fpr_wr | input | 1 | A floating-point register is being written |
| fp_dirty | output | 1 | Floating-point context changed (one-cycle pulse) |
| csr_sel | input | 2 | View select: 0 none, 1 flags, 2 rounding mode, 3 combined |
| csr_we | input | 1 | Write strobe for the selected view |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data of the selected view |

## Verification
The assertions assume that `csr_sel`, `csr_we`, `exc_valid` and `fpr_wr` change only between clock edges. They also assume that `exc_bits` is meaningful only while `exc_valid` is high. The rounding checks are qualified by `op_valid`, so idle values of `op_rm` are never judged. The stimulus changes every input on the falling edge and returns the strobes to zero after one cycle. This lets each accumulate, write or register-write event map onto exactly one rising edge. It also exercises the same-cycle write-versus-accumulate collision on purpose, in each of the three view selections.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
   localparam int FLAG_W = 5;
   localparam int RM_W   = 3;

   typedef logic [FLAG_W-1:0] fflags_t;
   typedef logic [RM_W-1:0]   frm_t;

   typedef enum logic [1:0] {
      CSR_NONE  = 2'd0,
      CSR_FLAGS = 2'd1,
      CSR_RMODE = 2'd2,
      CSR_ALL   = 2'd3
   } csr_sel_e;

   localparam frm_t RM_DYNAMIC = frm_t'(7);
   localparam int   ALL_W      = FLAG_W + RM_W;
endpackage

// File: rtl/fp_rm_resolve.sv
module fp_rm_resolve
   import fpcsr_pkg::*;
#(
   parameter int MAX_LEGAL_RM = 4
) (
   input  logic op_valid,
   input  frm_t inst_rm,
   input  frm_t dyn_rm,
   output frm_t eff_rm,
   output logic illegal
);
   if (MAX_LEGAL_RM >= int'(RM_DYNAMIC)) begin : g_bad_max
      $error("MAX_LEGAL_RM must be below the dynamic selector");
   end

   always_comb begin
      eff_rm  = (inst_rm == RM_DYNAMIC) ? dyn_rm : inst_rm;
      illegal = op_valid && (int'(eff_rm) > MAX_LEGAL_RM);
   end
endmodule

// File: rtl/fp_flag_accum.sv
module fp_flag_accum
   import fpcsr_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    exc_valid,
   input  fflags_t exc_bits,
   input  logic    wr_en,
   input  fflags_t wr_flags,
   output fflags_t flags,
   output logic    acc_hit
);
   assign acc_hit = exc_valid && (exc_bits != '0);

   for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)                      flags[i] <= 1'b0;
         else if (wr_en)                  flags[i] <= wr_flags[i];
         else if (exc_valid && exc_bits[i]) flags[i] <= 1'b1;
      end

      // R5: a set flag stays set unless software writes it
      p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !wr_en) |=> flags[i]);
   end
endmodule

// File: rtl/fp_rmode_reg.sv
module fp_rmode_reg
   import fpcsr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  frm_t wr_rm,
   output frm_t rm
);
   always_ff @(posedge clk) begin
      if (!rst_n)     rm <= '0;
      else if (wr_en) rm <= wr_rm;
   end

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rm));
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
   import fpcsr_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter int MAX_LEGAL_RM = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_valid,
   input  logic [2:0]      op_rm,
   output logic [2:0]      eff_rm,
   output logic            rm_illegal,
   input  logic            exc_valid,
   input  logic [4:0]      exc_bits,
   input  logic            fpr_wr,
   output logic            fp_dirty,
   input  logic [1:0]      csr_sel,
   input  logic            csr_we,
   input  logic [XLEN-1:0] csr_wdata,
   output logic [XLEN-1:0] csr_rdata
);
   if (XLEN < ALL_W) begin : g_bad_xlen
      $error("XLEN too narrow for the combined view");
   end

   csr_sel_e sel;
   fflags_t  flags_q;
   frm_t     rm_q;
   logic     flags_we, rm_we, acc_hit, dirty_q;
   frm_t     rm_wval;

   assign sel      = csr_sel_e'(csr_sel);
   assign flags_we = csr_we && (sel == CSR_FLAGS || sel == CSR_ALL);
   assign rm_we    = csr_we && (sel == CSR_RMODE || sel == CSR_ALL);
   assign rm_wval  = (sel == CSR_ALL) ? csr_wdata[ALL_W-1:FLAG_W] : csr_wdata[RM_W-1:0];

   fp_rm_resolve #(.MAX_LEGAL_RM(MAX_LEGAL_RM)) u_resolve (
      .op_valid (op_valid),
      .inst_rm  (op_rm),
      .dyn_rm   (rm_q),
      .eff_rm   (eff_rm),
      .illegal  (rm_illegal)
   );

   fp_flag_accum u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .exc_valid(exc_valid),
      .exc_bits (exc_bits),
      .wr_en    (flags_we),
      .wr_flags (csr_wdata[FLAG_W-1:0]),
      .flags    (flags_q),
      .acc_hit  (acc_hit)
   );

   fp_rmode_reg u_rmode (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (rm_we),
      .wr_rm (rm_wval),
      .rm    (rm_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) dirty_q <= 1'b0;
      else        dirty_q <= acc_hit || fpr_wr;
   end
   assign fp_dirty = dirty_q;

   always_comb begin
      csr_rdata = '0;
      unique case (sel)
         CSR_FLAGS: csr_rdata[FLAG_W-1:0] = flags_q;
         CSR_RMODE: csr_rdata[RM_W-1:0]   = rm_q;
         CSR_ALL:   csr_rdata[ALL_W-1:0]  = {rm_q, flags_q};
         default:   csr_rdata = '0;
      endcase
   end

   // R2: static legal modes pass straight through
   p_static_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_rm <= 3'd4) |-> (eff_rm == op_rm && !rm_illegal));
   // R3: dynamic selector returns the stored mode
   p_dyn_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_rm == 3'd7) |-> (eff_rm == csr_rdata_rm_view()));
   // R4: reserved static encodings are illegal
   p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_rm == 3'd5 || op_rm == 3'd6)) |-> rm_illegal);
   // R6: zero vector without register write gives no dirty pulse
   p_no_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!fpr_wr && (!exc_valid || exc_bits == '0)) |=> !fp_dirty);
   // R7: a nonzero accumulate is followed by a dirty pulse
   p_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_bits != '0) |=> fp_dirty);
   // R9: combined write lands in both fields at one edge
   p_comb_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && csr_sel == 2'd3) |=>
         (flags_q == $past(csr_wdata[4:0]) && rm_q == $past(csr_wdata[7:5])));
   // R10: flags write overrides a colliding accumulate
   p_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && csr_sel == 2'd1) |=> (flags_q == $past(csr_wdata[4:0])));
   // R11: upper read bits are zero
   p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rdata[XLEN-1:ALL_W] == '0);

   function automatic frm_t csr_rdata_rm_view();
      return rm_q;
   endfunction
endmodule

// File: tb/sim_fpcsr_unit.sv
`timescale 1ns/1ps
module sim_fpcsr_unit;
   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            op_valid = 1'b0;
   logic [2:0]      op_rm = '0;
   logic [2:0]      eff_rm;
   logic            rm_illegal;
   logic            exc_valid = 1'b0;
   logic [4:0]      exc_bits = '0;
   logic            fpr_wr = 1'b0;
   logic            fp_dirty;
   logic [1:0]      csr_sel = '0;
   logic            csr_we = 1'b0;
   logic [XLEN-1:0] csr_wdata = '0;
   logic [XLEN-1:0] csr_rdata;

   always #5 clk = ~clk;

   fpcsr_unit #(.XLEN(XLEN)) u0 (.*);

   typedef struct {
      int          kind;   // 0 rdata, 1 eff_rm, 2 illegal, 3 dirty
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t queue_q[$];
   event  sample_ev;
   int    n_run = 0, n_fail = 0;
   bit    done = 0;

   // model state
   logic [4:0] m_flags = '0;
   logic [2:0] m_rm = '0;

   // monitor
   initial forever begin
      @(sample_ev);
      while (queue_q.size() > 0) begin
         item_t it;
         logic [31:0] got;
         it = queue_q.pop_front();
         case (it.kind)
            0: got = csr_rdata;
            1: got = 32'(eff_rm);
            2: got = 32'(rm_illegal);
            default: got = 32'(fp_dirty);
         endcase
         n_run++;
         if (got !== it.exp) begin
            n_fail++;
            $display("FAIL %s kind=%0d got=%h exp=%h", it.tag, it.kind, got, it.exp);
         end
      end
   end

   task automatic expect_val(int kind, logic [31:0] exp, string tag);
      item_t it;
      it.kind = kind; it.exp = exp; it.tag = tag;
      queue_q.push_back(it);
   endtask

   task automatic fire();
      -> sample_ev;
      #1;
   endtask

   task automatic check_read(logic [1:0] sel, logic [31:0] exp, string tag);
      @(negedge clk);
      csr_sel = sel; csr_we = 1'b0;
      #1;
      expect_val(0, exp, tag);
      fire();
   endtask

   task automatic check_op(logic [2:0] rm, logic [2:0] exp_rm, bit exp_ill, string tag);
      @(negedge clk);
      op_valid = 1'b1; op_rm = rm;
      #1;
      if (!exp_ill) expect_val(1, 32'(exp_rm), tag);
      expect_val(2, 32'(exp_ill), tag);
      fire();
      op_valid = 1'b0;
   endtask

   // one edge of stimulus: optional CSR write, accumulate, register write
   task automatic step(bit we, logic [1:0] sel, logic [31:0] wd,
                       bit ev, logic [4:0] eb, bit fw, string tag);
      bit fl_w, rm_w;
      @(negedge clk);
      csr_we = we; csr_sel = sel; csr_wdata = wd;
      exc_valid = ev; exc_bits = eb; fpr_wr = fw;
      fl_w = we && (sel == 2'd1 || sel == 2'd3);
      rm_w = we && (sel == 2'd2 || sel == 2'd3);
      if (fl_w)    m_flags = wd[4:0];
      else if (ev) m_flags = m_flags | eb;
      if (rm_w) m_rm = (sel == 2'd3) ? wd[7:5] : wd[2:0];
      @(negedge clk);
      expect_val(3, 32'((ev && eb != 0) || fw), tag);
      fire();
      csr_we = 1'b0; exc_valid = 1'b0; exc_bits = '0; fpr_wr = 1'b0;
      csr_sel = 2'd0; csr_wdata = '0;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      check_read(2'd3, 32'h0, "R1 combined after reset");
      check_read(2'd1, 32'h0, "R1 flags after reset");
      @(negedge clk); #1; expect_val(3, 0, "R1 dirty idle"); fire();

      // R2 static modes
      for (int r = 0; r <= 4; r++) check_op(3'(r), 3'(r), 0, "R2 static mode");
      // R4 reserved static
      check_op(3'd5, 3'd0, 1, "R4 static 5");
      check_op(3'd6, 3'd0, 1, "R4 static 6");

      // R8 rounding-mode view, R3 dynamic
      step(1, 2'd2, 32'hFFFF_FFF3, 0, 0, 0, "R8 rm write");
      check_read(2'd2, 32'(m_rm), "R8 rm view");
      check_op(3'd7, 3'd3, 0, "R3 dynamic to 3");

      // R5 / R7 accumulation
      step(0, 2'd0, 0, 1, 5'b00001, 0, "R7 dirty inexact");
      check_read(2'd1, 32'h01, "R5 inexact bit 0");
      step(0, 2'd0, 0, 1, 5'b10000, 0, "R7 dirty invalid");
      check_read(2'd1, 32'h11, "R5 sticky OR");
      // R6 zero vector
      step(0, 2'd0, 0, 1, 5'b00000, 0, "R6 no dirty");
      check_read(2'd1, 32'h11, "R6 flags unchanged");
      // R7 register write
      step(0, 2'd0, 0, 0, 0, 1, "R7 fpr write dirty");
      check_read(2'd1, 32'h11, "R7 flags kept");

      // R9 / R11 combined write with junk upper bits
      step(1, 2'd3, 32'hFFFF_FFA5, 0, 0, 0, "R9 comb write");
      check_read(2'd3, 32'hA5, "R11 combined upper zero");
      check_read(2'd2, 32'h5, "R9 rm field 7:5");
      check_read(2'd1, 32'h5, "R9 flags field 4:0");
      check_op(3'd7, 3'd0, 1, "R4 dynamic 5 illegal");

      // R8 flags view write
      step(1, 2'd1, 32'hFFFF_FFEA, 0, 0, 0, "R8 flags write");
      check_read(2'd1, 32'h0A, "R8 flags view");

      // R10 collisions
      step(1, 2'd1, 32'h0, 1, 5'b01000, 0, "R10 flags write vs acc");
      check_read(2'd1, 32'h0, "R10 flags write wins");
      step(1, 2'd2, 32'h2, 1, 5'b00010, 0, "R10 rm write with acc");
      check_read(2'd3, {24'h0, 3'd2, 5'b00010}, "R10 rm write lets acc in");
      step(1, 2'd3, 32'h0, 1, 5'b11111, 0, "R10 comb write vs acc");
      check_read(2'd3, 32'h0, "R10 comb write wins");

      // R11 select 0
      step(1, 2'd3, 32'h0000_00E4, 0, 0, 0, "R11 setup");
      step(1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0, "R11 none write");
      check_read(2'd0, 32'h0, "R11 none reads zero");
      check_read(2'd3, 32'hE4, "R11 none write ignored");
      check_op(3'd7, 3'd7, 1, "R4 dynamic 7 illegal");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule